// File: doc/BRIEF.md
# Sampled-Amplitude to Rate-Coded Event Encoder

This block turns a stream of signed converter samples into bursts of address-event words. Each accepted sample is rescaled into a signed fixed-point value with 8 integer and 8 fraction bits by default. The block sums a fixed, power-of-two count of these values and divides the sum by that count, rounding to the nearest value. That rounded window average sets how many events leave the block: the magnitude of the average is divided by a threshold, and the integer part of the result is the event count.

Every event in a burst carries one of two addresses, chosen by the sign of the average, and a polarity bit that a consumer can read without decoding the address. The block loads the average and the event count into registered diagnostic outputs at the end of each window. Two sticky flags record misuse. One is set when a sample is offered while the input is not ready. The other is set when the threshold is zero, and the input stays closed while the threshold is zero. The input does not accept a new sample until the current burst has drained.

Top module: `spike_rate_encoder`

## Requirements
- R1: An input sample holds 12 signed bits with 7 fraction bits. It becomes a 16-bit signed value with 8 fraction bits, which is the sample times 2. A window of identical samples reports exactly that value as its average.
- R2: Each window holds 8 accepted samples. The average equals (|sum| + 4) / 8, truncated, with the sign of the sum, so exact halves round away from zero. When a window completes, `win_strobe` is high for exactly one cycle, and `win_avg` holds the average from that cycle onward.
- R3: `win_events` equals floor(|average| / `thresh`), where `thresh` is the value present when the window's last sample is accepted. The number of `evt_valid`/`evt_ready` handshakes in the burst equals `win_events`.
- R4: A negative average gives events with address 0x050 (base 0x040 plus offset 0x010) and `evt_neg` = 1. An average of zero or more gives address 0x040 and `evt_neg` = 0. A negative sum that rounds to zero counts as non-negative.
- R5: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_addr` and `evt_neg` stay unchanged into the next cycle.
- R6: `smp_ready` is low from the last sample of a window until the final event of its burst has been accepted. A window with zero events produces no event and reopens the input without emitting anything.
- R7: If `smp_valid` is high while `smp_ready` is low, `drop_flag` becomes 1 and stays 1 until reset. The offered sample does not enter any window.
- R8: While `thresh` is zero, `smp_ready` is low and `thresh_err` becomes 1. The flag stays 1 after the threshold becomes nonzero again.
- R9: After reset, `evt_valid`, `win_strobe`, `drop_flag` and `thresh_err` are 0, `win_avg` and `win_events` are 0, and `smp_ready` is 1 when `thresh` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block can take a sample this cycle |
| smp_data | input | 12 | Signed converter sample |
| thresh | input | 16 | Unsigned amplitude per event, same scaling as the average |
| evt_valid | output | 1 | Event word pending |
| evt_ready | input | 1 | Consumer takes the pending event |
| evt_addr | output | 10 | Event address, picked by the sign of the average |
| evt_neg | output | 1 | Event polarity, 1 for a negative average |
| win_strobe | output | 1 | One-cycle pulse when the diagnostics update |
| win_avg | output | 16 | Signed rounded average of the last window |
| win_events | output | 16 | Event count of the last window |
| drop_flag | output | 1 | Sticky: sample offered while not ready |
| thresh_err | output | 1 | Sticky: threshold seen at zero |

## Verification
The hardest case to reach from the ports is a sample offered while a burst is held open. The bench has to keep `evt_ready` low right after the diagnostic strobe, raise `smp_valid` in that window, and then drain the burst. A following window of known samples then shows that the dropped value never reached the accumulator. Rounding cases are built from windows with one nonzero sample, which put the sum exactly on a half step or just below it, in both signs.

// File: rtl/sre_pkg.sv
`timescale 1ns/1ps
package sre_pkg;
  // Control phases of the encoder
  typedef enum logic [1:0] {
    ST_ACCUM  = 2'd0,  // taking samples into the window
    ST_DIVIDE = 2'd1,  // computing the event count
    ST_EMIT   = 2'd2   // draining the event burst
  } sre_state_e;
endpackage

// File: rtl/sre_reset_sync.sv
`timescale 1ns/1ps
module sre_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q, stage2_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/sre_quantise.sv
`timescale 1ns/1ps
module sre_quantise #(
  parameter int ADC_W    = 12,
  parameter int ADC_FRAC = 7,
  parameter int Q_W      = 16,
  parameter int Q_FRAC   = 8
) (
  input  logic [ADC_W-1:0]     raw,
  output logic signed [Q_W-1:0] q
);
  logic signed [ADC_W-1:0] s_raw;
  logic signed [Q_W-1:0]   s_ext;

  assign s_raw = $signed(raw);
  assign s_ext = Q_W'(s_raw);

  // Align the binary point: widen fraction or drop surplus fraction bits
  generate
    if (Q_FRAC >= ADC_FRAC) begin : g_up
      localparam int SHL = Q_FRAC - ADC_FRAC;
      assign q = s_ext <<< SHL;
    end else begin : g_down
      localparam int SHR = ADC_FRAC - Q_FRAC;
      assign q = s_ext >>> SHR;
    end
  endgenerate
endmodule

// File: rtl/sre_window_acc.sv
`timescale 1ns/1ps
module sre_window_acc #(
  parameter int Q_W      = 16,
  parameter int WIN_LOG2 = 3   // at least 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic signed [Q_W-1:0] q_in,
  output logic                  win_last,
  output logic [Q_W-1:0]        avg_mag,
  output logic                  avg_neg
);
  localparam int SUM_W = Q_W + WIN_LOG2;
  localparam int RND_W = SUM_W + 1;
  localparam logic [RND_W-1:0] HALF = RND_W'(1) << (WIN_LOG2 - 1);

  logic signed [SUM_W-1:0] sum_q, sum_d, total;
  logic [WIN_LOG2-1:0]     idx_q, idx_d;
  logic [SUM_W-1:0]        mag;
  logic [RND_W-1:0]        rnd;

  // Rounded magnitude of the running sum including the current sample
  always_comb begin
    total    = sum_q + SUM_W'(q_in);
    mag      = total[SUM_W-1] ? unsigned'(-total) : unsigned'(total);
    rnd      = {1'b0, mag} + HALF;
    avg_mag  = Q_W'(rnd >> WIN_LOG2);
    avg_neg  = total[SUM_W-1] && (avg_mag != '0);
    win_last = take && (idx_q == '1);
  end

  // Next state of the window accumulator
  always_comb begin
    sum_d = win_last ? '0 : total;
    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      sum_q <= sum_d;
      idx_q <= idx_d;
    end
  end

  // R2: the sample counter only moves on an accepted sample
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(idx_q));
endmodule

// File: rtl/sre_seq_divider.sv
`timescale 1ns/1ps
module sre_seq_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d, quo_q, quo_d, dsr_q, dsr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [W:0]       shifted;
  logic             fits;

  // One restoring step per cycle, W steps in total
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = shifted >= {1'b0, dsr_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    dsr_d   = dsr_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (start) begin
      rem_d  = '0;
      quo_d  = dividend;
      dsr_d  = divisor;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? W'(shifted - {1'b0, dsr_q}) : W'(shifted);
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(W - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dsr_q  <= dsr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  // R3: the partial remainder never reaches the divisor during a division
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dsr_q));
  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/sre_event_emitter.sv
`timescale 1ns/1ps
module sre_event_emitter #(
  parameter int                Q_W        = 16,
  parameter int                ADDR_W     = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 10'h040,
  parameter logic [ADDR_W-1:0] NEG_OFFSET = 10'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [Q_W-1:0]    count,
  input  logic              neg,
  input  logic              evt_ready,
  output logic              evt_valid,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              evt_neg
);
  localparam logic [ADDR_W-1:0] NEG_ADDR = BASE_ADDR + NEG_OFFSET;

  logic [Q_W-1:0]    left_q, left_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pol_q, pol_d, accept, upd_en;

  assign evt_valid = (left_q != '0);
  assign accept    = evt_valid && evt_ready;
  assign upd_en    = load || accept;

  always_comb begin
    left_d = left_q;
    addr_d = addr_q;
    pol_d  = pol_q;
    if (load) begin
      left_d = count;
      addr_d = neg ? NEG_ADDR : BASE_ADDR;
      pol_d  = neg;
    end else if (accept) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      addr_q <= BASE_ADDR;
      pol_q  <= 1'b0;
    end else if (upd_en) begin
      left_q <= left_d;
      addr_q <= addr_d;
      pol_q  <= pol_d;
    end
  end

  assign evt_addr = addr_q;
  assign evt_neg  = pol_q;

  // R5: a stalled event holds still
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_addr) && $stable(evt_neg)));
  // R4: address agrees with polarity
  p_addr_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_addr == (evt_neg ? NEG_ADDR : BASE_ADDR)));
  // R6: a new burst is only loaded once the previous one has drained
  p_load_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !evt_valid);
endmodule

// File: rtl/spike_rate_encoder.sv
`timescale 1ns/1ps
module spike_rate_encoder #(
  parameter int                ADC_W      = 12,
  parameter int                ADC_FRAC   = 7,
  parameter int                Q_INT      = 8,
  parameter int                Q_FRAC     = 8,
  parameter int                WIN_LOG2   = 3,
  parameter int                ADDR_W     = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 10'h040,
  parameter logic [ADDR_W-1:0] NEG_OFFSET = 10'h010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [ADC_W-1:0]        smp_data,
  input  logic [Q_INT+Q_FRAC-1:0] thresh,
  output logic                    evt_valid,
  input  logic                    evt_ready,
  output logic [ADDR_W-1:0]       evt_addr,
  output logic                    evt_neg,
  output logic                    win_strobe,
  output logic [Q_INT+Q_FRAC-1:0] win_avg,
  output logic [Q_INT+Q_FRAC-1:0] win_events,
  output logic                    drop_flag,
  output logic                    thresh_err
);
  import sre_pkg::*;

  localparam int Q_W = Q_INT + Q_FRAC;

  logic                  rst_s;
  logic signed [Q_W-1:0] q_val;
  sre_state_e            state_q, state_d;
  logic                  thr_zero, take, win_last, avg_neg, div_done;
  logic [Q_W-1:0]        avg_mag, quotient;
  logic [Q_W-1:0]        pend_avg_q, pend_avg_d;
  logic [Q_W-1:0]        avg_out_q, cnt_out_q;
  logic                  pend_neg_q;
  logic                  strobe_q, drop_q, drop_d, terr_q, terr_d;

  sre_reset_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  sre_quantise #(
    .ADC_W(ADC_W), .ADC_FRAC(ADC_FRAC), .Q_W(Q_W), .Q_FRAC(Q_FRAC)
  ) u_quant (
    .raw (smp_data),
    .q   (q_val)
  );

  assign thr_zero  = (thresh == '0);
  assign smp_ready = (state_q == ST_ACCUM) && !thr_zero;
  assign take      = smp_valid && smp_ready;

  sre_window_acc #(
    .Q_W(Q_W), .WIN_LOG2(WIN_LOG2)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_s),
    .take     (take),
    .q_in     (q_val),
    .win_last (win_last),
    .avg_mag  (avg_mag),
    .avg_neg  (avg_neg)
  );

  sre_seq_divider #(
    .W(Q_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (win_last),
    .dividend (avg_mag),
    .divisor  (thresh),
    .done     (div_done),
    .quotient (quotient)
  );

  sre_event_emitter #(
    .Q_W(Q_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NEG_OFFSET(NEG_OFFSET)
  ) u_emit (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (div_done),
    .count     (quotient),
    .neg       (pend_neg_q),
    .evt_ready (evt_ready),
    .evt_valid (evt_valid),
    .evt_addr  (evt_addr),
    .evt_neg   (evt_neg)
  );

  // Phase sequencing
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACCUM:  if (win_last) state_d = ST_DIVIDE;
      ST_DIVIDE: if (div_done) state_d = (quotient == '0) ? ST_ACCUM : ST_EMIT;
      ST_EMIT:   if (!evt_valid) state_d = ST_ACCUM;
      default:   state_d = ST_ACCUM;
    endcase
  end

  // Signed average and sticky flags
  always_comb begin
    pend_avg_d = avg_neg ? (~avg_mag + 1'b1) : avg_mag;
    drop_d     = drop_q || (smp_valid && !smp_ready);
    terr_d     = terr_q || thr_zero;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_ACCUM;
      drop_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_d;
      terr_q  <= terr_d;
    end
  end

  // Window result held while the count is computed
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_avg_q <= '0;
      pend_neg_q <= 1'b0;
    end else if (win_last) begin
      pend_avg_q <= pend_avg_d;
      pend_neg_q <= avg_neg;
    end
  end

  // Diagnostics, loaded when the count is known
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      avg_out_q <= '0;
      cnt_out_q <= '0;
    end else if (div_done) begin
      avg_out_q <= pend_avg_q;
      cnt_out_q <= quotient;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) strobe_q <= 1'b0;
    else        strobe_q <= div_done;
  end

  assign win_strobe = strobe_q;
  assign win_avg    = avg_out_q;
  assign win_events = cnt_out_q;
  assign drop_flag  = drop_q;
  assign thresh_err = terr_q;

  // R6: input stays closed while a burst is pending
  p_closed_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_s)
    evt_valid |-> !smp_ready);
  // R3: the emitter holds events exactly when the reported count is nonzero
  p_count_link_r3: assert property (@(posedge clk) disable iff (!rst_s)
    win_strobe |-> (evt_valid == (win_events != '0)));
  // R2: diagnostic strobe is one cycle wide
  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_s)
    win_strobe |=> !win_strobe);
  // R7: a refused offer sets the flag, which then stays set
  p_drop_set_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (smp_valid && !smp_ready) |=> drop_flag);
  p_drop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_s)
    drop_flag |=> drop_flag);
  // R8: a zero threshold is recorded and remembered
  p_thr_flag_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (thresh == '0) |=> thresh_err);
  p_thr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_s)
    thresh_err |=> thresh_err);
endmodule

// File: tb/spike_rate_encoder_tb_top.sv
`timescale 1ns/1ps
module spike_rate_encoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [11:0] smp_data = '0;
  logic [15:0] thresh = 16'd25;
  logic        evt_valid;
  logic        evt_ready = 1'b1;
  logic [9:0]  evt_addr;
  logic        evt_neg;
  logic        win_strobe;
  logic [15:0] win_avg, win_events;
  logic        drop_flag, thresh_err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  int buf_s [8];

  always #2.5 clk = ~clk;

  spike_rate_encoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .thresh(thresh),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_addr(evt_addr), .evt_neg(evt_neg),
    .win_strobe(win_strobe), .win_avg(win_avg), .win_events(win_events),
    .drop_flag(drop_flag), .thresh_err(thresh_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 8; i++) buf_s[i] = v;
  endtask

  // Feeds buf_s as one window, then checks diagnostics and the burst
  task automatic run_window(input string req, input int thr, input bit stall, input bit inject);
    int sum, mag, am, avg, cnt, n, addr_bad, hold_bad;
    bit neg, got_strobe, ended, prev_stall;
    logic [9:0] exp_addr, prev_addr;
    logic prev_pol;
    thresh = thr[15:0];
    sum = 0;
    for (int i = 0; i < 8; i++) sum += buf_s[i] * 2;
    mag = (sum < 0) ? -sum : sum;
    am  = (mag + 4) / 8;
    avg = (sum < 0) ? -am : am;
    neg = (avg < 0);
    cnt = am / thr;
    exp_addr = neg ? 10'h050 : 10'h040;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      while (!smp_ready) @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = buf_s[i][11:0];
      @(posedge clk);
      #1 smp_valid = 1'b0;
    end
    got_strobe = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (win_strobe) begin got_strobe = 1; break; end
    end
    chk(got_strobe, "R2", "diagnostic strobe", int'(got_strobe), 1);
    chk($signed(win_avg) == avg, req, "window average", int'($signed(win_avg)), avg);
    chk(int'(win_events) == cnt, "R3", "reported event count", int'(win_events), cnt);
    if (cnt > 0) chk(!smp_ready, "R6", "input closed at burst start", int'(smp_ready), 0);
    if (inject) begin
      evt_ready = 1'b0;
      smp_valid = 1'b1;
      smp_data  = 12'd1000;
      @(posedge clk);
      #1 smp_valid = 1'b0;
      @(negedge clk);
      chk(drop_flag, "R7", "drop flag after refused offer", int'(drop_flag), 1);
    end
    n = 0; addr_bad = 0; hold_bad = 0; ended = 0; prev_stall = 0;
    prev_addr = '0; prev_pol = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      if (smp_ready && !evt_valid) begin ended = 1; break; end
      evt_ready = stall ? ((c % 3) == 2) : 1'b1;
      if (prev_stall && (!evt_valid || evt_addr != prev_addr || evt_neg != prev_pol)) hold_bad++;
      if (evt_valid && (evt_addr != exp_addr || evt_neg != neg)) addr_bad++;
      if (evt_valid && evt_ready) n++;
      prev_stall = evt_valid && !evt_ready;
      prev_addr  = evt_addr;
      prev_pol   = evt_neg;
      @(negedge clk);
    end
    evt_ready = 1'b1;
    chk(ended, "R6", "input reopens after burst", int'(ended), 1);
    chk(n == cnt, "R3", "accepted events", n, cnt);
    if (cnt > 0) chk(addr_bad == 0, "R4", "address/polarity mismatches", addr_bad, 0);
    if (stall) chk(hold_bad == 0, "R5", "changes while stalled", hold_bad, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(smp_ready == 1'b1, "R9", "ready after reset", int'(smp_ready), 1);
    chk(evt_valid == 1'b0, "R9", "no event after reset", int'(evt_valid), 0);
    chk(win_strobe == 1'b0, "R9", "no strobe after reset", int'(win_strobe), 0);
    chk(drop_flag == 1'b0, "R9", "drop flag clear", int'(drop_flag), 0);
    chk(thresh_err == 1'b0, "R9", "threshold flag clear", int'(thresh_err), 0);
    chk(win_avg == 16'd0 && win_events == 16'd0, "R9", "diagnostics zero", int'(win_avg), 0);
  endtask

  task automatic t_conversion;
    fill(40);
    run_window("R1", 25, 0, 0);
    chk($signed(win_avg) == 80, "R1", "sample scaled by two", int'($signed(win_avg)), 80);
  endtask

  task automatic t_negative_stall;
    fill(-100);
    run_window("R4", 30, 1, 0);
    chk(win_events == 16'd6, "R5", "stalled negative burst size", int'(win_events), 6);
  endtask

  task automatic t_rounding;
    fill(0); buf_s[0] = 2;
    run_window("R2", 1, 0, 0);   // +4/8 rounds up to 1
    fill(0); buf_s[0] = -2;
    run_window("R2", 1, 0, 0);   // -4/8 rounds away to -1
    fill(0); buf_s[0] = 1;
    run_window("R6", 1, 0, 0);   // 2/8 rounds to 0, no events
    fill(0); buf_s[0] = -1;
    run_window("R4", 1, 0, 0);   // negative sum rounds to 0, non-negative
  endtask

  task automatic t_threshold_edge;
    fill(40);
    run_window("R3", 81, 0, 0);  // just above the average: nothing
    run_window("R3", 80, 0, 0);  // equal: one event
  endtask

  task automatic t_mixed_extreme;
    buf_s[0] = 100; buf_s[1] = -50; buf_s[2] = 30;  buf_s[3] = 7;
    buf_s[4] = -3;  buf_s[5] = 0;   buf_s[6] = 90;  buf_s[7] = -120;
    run_window("R3", 3, 1, 0);
    fill(-2048);
    run_window("R1", 1024, 0, 0);
    fill(2047);
    run_window("R1", 1000, 1, 0);
  endtask

  task automatic t_drop;
    chk(drop_flag == 1'b0, "R7", "flag clear before misuse", int'(drop_flag), 0);
    fill(50);
    run_window("R7", 20, 0, 1);
    fill(10);
    run_window("R7", 5, 0, 0);   // dropped value must not appear in this average
    chk(drop_flag == 1'b1, "R7", "flag still set", int'(drop_flag), 1);
  endtask

  task automatic t_zero_threshold;
    @(negedge clk);
    thresh = 16'd0;
    @(negedge clk);
    @(negedge clk);
    chk(smp_ready == 1'b0, "R8", "ready low at zero threshold", int'(smp_ready), 0);
    chk(thresh_err == 1'b1, "R8", "threshold flag set", int'(thresh_err), 1);
    thresh = 16'd5;
    @(negedge clk);
    @(negedge clk);
    chk(thresh_err == 1'b1, "R8", "threshold flag sticky", int'(thresh_err), 1);
    chk(smp_ready == 1'b1, "R8", "ready back with nonzero threshold", int'(smp_ready), 1);
    fill(10);
    run_window("R8", 5, 0, 0);
  endtask

  initial begin
    t_reset();
    t_conversion();
    t_negative_stall();
    t_rounding();
    t_threshold_edge();
    t_mixed_extreme();
    t_drop();
    t_zero_threshold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule